// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block produces data memory addresses from a small bank of pointer sets. Each set holds four registers: an index (the live pointer), a modify (the step), a length and a base. On each address request the caller names one index set and either one modify register or an immediate step. It also selects premodify or postmodify addressing and says whether the updated pointer is written back.

When the length register of the selected set is nonzero, the updated pointer wraps modulo that length. It stays inside the region that starts at the base value of that set. A length of zero gives plain linear stepping. Registers are loaded and read back through a simple register port, addressed by register kind and set number. The register width is a parameter: 32 bits suits a data-memory instance and 24 bits a program-memory instance.

Top module: `cbuf_agen`

## Requirements
- R1: After reset every register of every kind and set reads back as zero.
- R2: A write with `wr_en` high stores `wr_data` into the register selected by `wr_kind` (0 index, 1 modify, 2 length, 3 base) and `wr_sel`. From the next cycle, `rd_data` shows the register selected by `rd_kind`/`rd_sel`, with the same encoding.
- R3: Writing a base register also loads the same value into the index register of that set.
- R4: In premodify mode (`req_pre`=1), `addr_out` equals index plus step modulo 2^AW, with no wrap. The index register is never changed by a premodify request, whatever `req_wb` is.
- R5: In postmodify mode (`req_pre`=0), `addr_out` equals the current index. If `req_wb`=1, the index becomes the updated value at the next clock edge. If `req_wb`=0, the index is left unchanged.
- R6: With length zero, the updated index is index plus step, truncated to AW bits.
- R7: With nonzero length L and base B, if (index − B) + step ≥ L, then the updated index is index + step − L (upward wrap).
- R8: With nonzero length L and base B, if (index − B) + step < 0, then the updated index is index + step + L (downward wrap).
- R9: The step is a signed two's-complement value at the register width. It comes from `req_imm` when `req_use_imm`=1, and otherwise from the modify register chosen by `req_msel`.
- R10: When a postmodify write-back and a register write (index or base kind) target the same set's index in one cycle, the write-back value wins for the index. A base write still updates the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind for write (0 index, 1 modify, 2 length, 3 base) |
| wr_sel | input | SELW | Set number for write |
| wr_data | input | AW | Write data |
| rd_kind | input | 2 | Register kind for read |
| rd_sel | input | SELW | Set number for read |
| rd_data | output | AW | Read data, combinational from stored state |
| req_valid | input | 1 | Address request |
| req_isel | input | SELW | Pointer set used as index, base and length |
| req_msel | input | SELW | Modify register number |
| req_use_imm | input | 1 | Use immediate step instead of modify register |
| req_imm | input | AW | Immediate signed step |
| req_pre | input | 1 | 1 premodify, 0 postmodify |
| req_wb | input | 1 | Write updated index back (postmodify only) |
| addr_out | output | AW | Generated address, combinational |

## Verification
The containment property assumes two things about a request. The pointer already lies within its buffer, and the step magnitude does not exceed the length. The property checks only requests that meet both conditions, so other requests stay legal stimulus. The bench sets up buffers through base writes, which place the pointer at the base. It then draws steps in a small signed range below the programmed lengths, so most requests fall inside the assumption. The read-back properties apply only in cycles where the read selection stays on the same register, and the bench sweeps the read selection to create such cycles.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;
   typedef enum logic [1:0] {
      KIND_IDX  = 2'd0,
      KIND_MOD  = 2'd1,
      KIND_LEN  = 2'd2,
      KIND_BASE = 2'd3
   } reg_kind_e;
endpackage

// File: rtl/cbuf_regbank.sv
module cbuf_regbank
   import cbuf_pkg::*;
#(
   parameter int AW    = 32,
   parameter int NSETS = 8,
   localparam int SELW = (NSETS > 1) ? $clog2(NSETS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  reg_kind_e       wr_kind,
   input  logic [SELW-1:0] wr_sel,
   input  logic [AW-1:0]   wr_data,
   input  logic            upd_en,
   input  logic [SELW-1:0] upd_sel,
   input  logic [AW-1:0]   upd_val,
   input  reg_kind_e       rd_kind,
   input  logic [SELW-1:0] rd_sel,
   output logic [AW-1:0]   rd_data,
   input  logic [SELW-1:0] isel,
   input  logic [SELW-1:0] msel,
   output logic [AW-1:0]   q_idx,
   output logic [AW-1:0]   q_len,
   output logic [AW-1:0]   q_base,
   output logic [AW-1:0]   q_mod
);
   logic [AW-1:0] idx_q  [NSETS];
   logic [AW-1:0] mod_q  [NSETS];
   logic [AW-1:0] len_q  [NSETS];
   logic [AW-1:0] base_q [NSETS];

   for (genvar s = 0; s < NSETS; s++) begin : g_set
      logic hit_w;
      logic hit_u;
      assign hit_w = wr_en && (wr_sel == SELW'(s));
      assign hit_u = upd_en && (upd_sel == SELW'(s));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            idx_q[s]  <= '0;
            mod_q[s]  <= '0;
            len_q[s]  <= '0;
            base_q[s] <= '0;
         end else begin
            if (hit_u) begin
               idx_q[s] <= upd_val;
            end else if (hit_w && (wr_kind == KIND_IDX || wr_kind == KIND_BASE)) begin
               idx_q[s] <= wr_data;
            end
            if (hit_w && wr_kind == KIND_MOD)  mod_q[s]  <= wr_data;
            if (hit_w && wr_kind == KIND_LEN)  len_q[s]  <= wr_data;
            if (hit_w && wr_kind == KIND_BASE) base_q[s] <= wr_data;
         end
      end
   end

   always_comb begin
      unique case (rd_kind)
         KIND_IDX:  rd_data = idx_q[rd_sel];
         KIND_MOD:  rd_data = mod_q[rd_sel];
         KIND_LEN:  rd_data = len_q[rd_sel];
         KIND_BASE: rd_data = base_q[rd_sel];
         default:   rd_data = '0;
      endcase
   end

   assign q_idx  = idx_q[isel];
   assign q_len  = len_q[isel];
   assign q_base = base_q[isel];
   assign q_mod  = mod_q[msel];
endmodule

// File: rtl/cbuf_modcalc.sv
module cbuf_modcalc #(
   parameter int AW        = 32,
   parameter bit EN_MODULO = 1'b1,
   localparam int XW       = AW + 2
) (
   input  logic [AW-1:0] idx,
   input  logic [AW-1:0] step,
   input  logic [AW-1:0] len,
   input  logic [AW-1:0] base,
   output logic [AW-1:0] lin_sum,
   output logic [AW-1:0] nxt_idx
);
   assign lin_sum = idx + step;

   if (EN_MODULO) begin : g_wrap
      logic signed [XW-1:0] rel;
      logic signed [XW-1:0] len_x;
      logic                 len_nz;
      logic                 over;
      logic                 under;

      assign rel    = $signed({2'b00, idx}) - $signed({2'b00, base})
                      + $signed({{2{step[AW-1]}}, step});
      assign len_x  = $signed({2'b00, len});
      assign len_nz = |len;
      assign over   = len_nz && (rel >= len_x);
      assign under  = len_nz && (rel < 0);

      always_comb begin
         if (over)       nxt_idx = lin_sum - len;
         else if (under) nxt_idx = lin_sum + len;
         else            nxt_idx = lin_sum;
      end
   end else begin : g_linear
      logic unused_ok;
      assign unused_ok = ^{len, base};
      assign nxt_idx   = lin_sum;
   end
endmodule

// File: rtl/cbuf_agen.sv
module cbuf_agen
   import cbuf_pkg::*;
#(
   parameter int AW        = 32,
   parameter int NSETS     = 8,
   parameter bit EN_MODULO = 1'b1,
   localparam int SELW     = (NSETS > 1) ? $clog2(NSETS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [1:0]      wr_kind,
   input  logic [SELW-1:0] wr_sel,
   input  logic [AW-1:0]   wr_data,
   input  logic [1:0]      rd_kind,
   input  logic [SELW-1:0] rd_sel,
   output logic [AW-1:0]   rd_data,
   input  logic            req_valid,
   input  logic [SELW-1:0] req_isel,
   input  logic [SELW-1:0] req_msel,
   input  logic            req_use_imm,
   input  logic [AW-1:0]   req_imm,
   input  logic            req_pre,
   input  logic            req_wb,
   output logic [AW-1:0]   addr_out
);
   if (AW < 4 || AW > 62) begin : g_bad_aw
      $error("cbuf_agen: AW out of supported range");
   end
   if (NSETS < 2 || NSETS > 64) begin : g_bad_sets
      $error("cbuf_agen: NSETS out of supported range");
   end

   logic [AW-1:0] q_idx, q_len, q_base, q_mod;
   logic [AW-1:0] eff_mod;
   logic [AW-1:0] lin_sum;
   logic [AW-1:0] upd_val;
   logic          upd_en;

   cbuf_regbank #(.AW(AW), .NSETS(NSETS)) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_kind (reg_kind_e'(wr_kind)),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .upd_en  (upd_en),
      .upd_sel (req_isel),
      .upd_val (upd_val),
      .rd_kind (reg_kind_e'(rd_kind)),
      .rd_sel  (rd_sel),
      .rd_data (rd_data),
      .isel    (req_isel),
      .msel    (req_msel),
      .q_idx   (q_idx),
      .q_len   (q_len),
      .q_base  (q_base),
      .q_mod   (q_mod)
   );

   assign eff_mod = req_use_imm ? req_imm : q_mod;

   cbuf_modcalc #(.AW(AW), .EN_MODULO(EN_MODULO)) calc_i (
      .idx     (q_idx),
      .step    (eff_mod),
      .len     (q_len),
      .base    (q_base),
      .lin_sum (lin_sum),
      .nxt_idx (upd_val)
   );

   assign upd_en   = req_valid && !req_pre && req_wb;
   assign addr_out = req_pre ? lin_sum : q_idx;
endmodule

// File: rtl/cbuf_agen_chk.sv
module cbuf_agen_chk #(
   parameter int AW    = 32,
   parameter int NSETS = 8,
   localparam int SELW = (NSETS > 1) ? $clog2(NSETS) : 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic [1:0]      wr_kind,
   input logic [SELW-1:0] wr_sel,
   input logic [AW-1:0]   wr_data,
   input logic [1:0]      rd_kind,
   input logic [SELW-1:0] rd_sel,
   input logic [AW-1:0]   rd_data,
   input logic            req_valid,
   input logic [SELW-1:0] req_isel,
   input logic            req_pre,
   input logic            req_wb,
   input logic [AW-1:0]   addr_out,
   input logic [AW-1:0]   q_idx,
   input logic [AW-1:0]   q_len,
   input logic [AW-1:0]   q_base,
   input logic [AW-1:0]   eff_mod,
   input logic [AW-1:0]   upd_val
);
   logic [AW-1:0] step_mag;
   logic          in_buf;
   logic          post_wb;
   logic          rd_on_isel;

   assign step_mag   = eff_mod[AW-1] ? (~eff_mod + 1'b1) : eff_mod;
   assign in_buf     = (q_idx - q_base) < q_len;
   assign post_wb    = req_valid && !req_pre && req_wb;
   assign rd_on_isel = (rd_kind == 2'd0) && (rd_sel == req_isel);

   // R5
   post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_pre && rd_on_isel) |-> (addr_out == rd_data));

   // R4
   pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_pre && !wr_en && rd_on_isel)
      |=> ((rd_kind == $past(rd_kind) && rd_sel == $past(rd_sel)) ? $stable(rd_data) : 1'b1));

   // R3
   base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_kind == 2'd3 && !(post_wb && req_isel == wr_sel))
      |=> ((rd_kind == 2'd0 && rd_sel == $past(wr_sel)) ? (rd_data == $past(wr_data)) : 1'b1));

   // R7 R8
   stay_in_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (post_wb && q_len != '0 && in_buf && step_mag <= q_len)
      |-> ((upd_val - q_base) < q_len));

   // R6
   linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (post_wb && q_len == '0) |-> (upd_val == q_idx + eff_mod));
endmodule

bind cbuf_agen cbuf_agen_chk #(.AW(AW), .NSETS(NSETS)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_kind   (wr_kind),
   .wr_sel    (wr_sel),
   .wr_data   (wr_data),
   .rd_kind   (rd_kind),
   .rd_sel    (rd_sel),
   .rd_data   (rd_data),
   .req_valid (req_valid),
   .req_isel  (req_isel),
   .req_pre   (req_pre),
   .req_wb    (req_wb),
   .addr_out  (addr_out),
   .q_idx     (q_idx),
   .q_len     (q_len),
   .q_base    (q_base),
   .eff_mod   (eff_mod),
   .upd_val   (upd_val)
);

// File: tb/cbuf_agen_tb_top.sv
module cbuf_agen_tb_top;
   localparam int AW    = 32;
   localparam int NSETS = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_kind = '0;
   logic [2:0]    wr_sel = '0;
   logic [AW-1:0] wr_data = '0;
   logic [1:0]    rd_kind = '0;
   logic [2:0]    rd_sel = '0;
   logic [AW-1:0] rd_data;
   logic          req_valid = 1'b0;
   logic [2:0]    req_isel = '0;
   logic [2:0]    req_msel = '0;
   logic          req_use_imm = 1'b0;
   logic [AW-1:0] req_imm = '0;
   logic          req_pre = 1'b0;
   logic          req_wb = 1'b0;
   logic [AW-1:0] addr_out;

   int total = 0;
   int bad = 0;

   logic [AW-1:0] mdl [4][NSETS];

   always #4 clk = ~clk;

   cbuf_agen #(.AW(AW), .NSETS(NSETS)) dut_i (.*);

   function automatic logic [AW-1:0] next_ptr(logic [AW-1:0] i, logic [AW-1:0] m,
                                              logic [AW-1:0] l, logic [AW-1:0] b);
      longint stp = longint'(signed'(m));
      longint rel = longint'(i) - longint'(b) + stp;
      longint sum = longint'(i) + stp;
      if (l != 0) begin
         if (rel >= longint'(l)) sum = sum - longint'(l);
         else if (rel < 0)       sum = sum + longint'(l);
      end
      return sum[AW-1:0];
   endfunction

   task automatic check(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(string tag,
                       logic we, logic [1:0] wk, int ws, logic [AW-1:0] wd,
                       logic rv, int is, int ms, logic ui, logic [AW-1:0] im,
                       logic pre, logic wb, logic [1:0] rk, int rs);
      logic [AW-1:0] i, m, exp_addr, nxt;
      @(negedge clk);
      wr_en = we; wr_kind = wk; wr_sel = 3'(ws); wr_data = wd;
      req_valid = rv; req_isel = 3'(is); req_msel = 3'(ms); req_use_imm = ui;
      req_imm = im; req_pre = pre; req_wb = wb; rd_kind = rk; rd_sel = 3'(rs);
      #2;
      i = mdl[0][is];
      m = ui ? im : mdl[1][ms];
      exp_addr = pre ? (i + m) : i;
      nxt = next_ptr(i, m, mdl[2][is], mdl[3][is]);
      check(tag, "rd_data", rd_data, mdl[rk][rs]);
      if (rv) check(tag, "addr_out", addr_out, exp_addr);
      if (we) begin
         mdl[wk][ws] = wd;
         if (wk == 2'd3) mdl[0][ws] = wd;
      end
      if (rv && !pre && wb) mdl[0][is] = nxt;
   endtask

   task automatic wr(string tag, int k, int s, logic [AW-1:0] d);
      step(tag, 1'b1, 2'(k), s, d, 1'b0, 0, 0, 1'b0, '0, 1'b0, 1'b0, 2'(k), s);
   endtask

   task automatic rd(string tag, int k, int s);
      step(tag, 1'b0, 2'(k), 0, '0, 1'b0, 0, 0, 1'b0, '0, 1'b0, 1'b0, 2'(k), s);
   endtask

   task automatic post(string tag, int s, logic wb);
      step(tag, 1'b0, 2'd0, 0, '0, 1'b1, s, s, 1'b0, '0, 1'b0, wb, 2'd0, s);
   endtask

   initial begin
      #(8 * 150000);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int k = 0; k < 4; k++)
         for (int s = 0; s < NSETS; s++) mdl[k][s] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: everything reads zero after reset
      for (int k = 0; k < 4; k++)
         for (int s = 0; s < NSETS; s++) rd("R1", k, s);

      // R2: each kind stores independently
      wr("R2", 1, 5, 32'h1234_5678);
      wr("R2", 2, 5, 32'h0000_00AA);
      wr("R2", 0, 5, 32'hDEAD_BEEF);
      rd("R2", 1, 5); rd("R2", 2, 5); rd("R2", 0, 5); rd("R2", 3, 5);

      // R3: base write loads index
      wr("R3", 3, 6, 32'h0000_0400);
      rd("R3", 0, 6); rd("R3", 3, 6);

      // R7: upward wrap, B=100 L=10 M=3
      wr("R7", 3, 1, 32'd100);
      wr("R7", 2, 1, 32'd10);
      wr("R7", 1, 1, 32'd3);
      for (int n = 0; n < 8; n++) post("R7", 1, 1'b1);
      rd("R7", 0, 1);

      // R8: downward wrap, B=200 L=8 M=-3
      wr("R8", 3, 2, 32'd200);
      wr("R8", 2, 2, 32'd8);
      wr("R8", 1, 2, 32'hFFFF_FFFD);
      for (int n = 0; n < 6; n++) post("R8", 2, 1'b1);
      rd("R8", 0, 2);

      // R4: premodify leaves index, even with wb set
      step("R4", 1'b0, 2'd0, 0, '0, 1'b1, 1, 1, 1'b0, '0, 1'b1, 1'b1, 2'd0, 1);
      step("R4", 1'b0, 2'd0, 0, '0, 1'b1, 1, 1, 1'b0, '0, 1'b1, 1'b0, 2'd0, 1);
      rd("R4", 0, 1);

      // R5: postmodify without write-back
      post("R5", 1, 1'b0);
      rd("R5", 0, 1);

      // R6: zero length, linear step across the top of the range
      wr("R6", 0, 3, 32'hFFFF_FFFE);
      wr("R6", 1, 3, 32'd5);
      post("R6", 3, 1'b1);
      rd("R6", 0, 3);

      // R9: immediate signed step and foreign modify register
      step("R9", 1'b0, 2'd0, 0, '0, 1'b1, 1, 1, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b1, 2'd0, 1);
      step("R9", 1'b0, 2'd0, 0, '0, 1'b1, 1, 5, 1'b0, '0, 1'b1, 1'b0, 2'd1, 5);
      rd("R9", 0, 1);

      // R10: write-back beats a same-cycle index write and base write
      step("R10", 1'b1, 2'd0, 1, 32'd555, 1'b1, 1, 1, 1'b0, '0, 1'b0, 1'b1, 2'd0, 1);
      rd("R10", 0, 1);
      step("R10", 1'b1, 2'd3, 1, 32'd104, 1'b1, 1, 1, 1'b0, '0, 1'b0, 1'b1, 2'd0, 1);
      rd("R10", 0, 1); rd("R10", 3, 1);

      // R7 R8: random traffic on small buffers
      for (int s = 0; s < NSETS; s++) begin
         wr("R2", 3, s, 32'(1000 * s + 64));
         wr("R2", 2, s, 32'(s + 5));
         wr("R2", 1, s, 32'($urandom_range(0, 8)) - 32'd4);
      end
      for (int n = 0; n < 600; n++) begin
         int s = $urandom_range(0, NSETS - 1);
         int ms = $urandom_range(0, NSETS - 1);
         logic ui = ($urandom_range(0, 3) == 0);
         logic [AW-1:0] im = 32'($urandom_range(0, 8)) - 32'd4;
         logic pre = ($urandom_range(0, 4) == 0);
         logic we = ($urandom_range(0, 9) == 0);
         step((n % 2 == 0) ? "R7" : "R8", we, 2'd1, ms, 32'($urandom_range(0, 8)) - 32'd4,
              1'b1, s, ms, ui, im, pre, 1'b1, 2'($urandom_range(0, 3)), s);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule